// File: doc/BRIEF.md
# Flash Block Self-Test Scanner

This block runs a production self-test over a NAND-style flash array. After a `start` pulse it visits every block in ascending order. It erases the block, then takes the pages in ascending order. For each page it streams a test pattern into the flash page buffer, issues a program command, reads the page back and compares every returned word with the pattern it sent. The pattern is derived from a seed and the page/word address, so a page that aliases onto another page returns the wrong data.

A block fails on the first of three conditions:
- any read word differs from the pattern;
- a busy phase or a read data phase lasts longer than the programmable timeout;
- an erase that completes with failure status.

The block under test is then reported to a bad-block table writer as a factory-bad entry, its remaining pages are skipped, and the scan moves to the next block. When the last block is finished, a one-cycle `done` pulse is raised and `bad_count` holds the number of reported blocks.

The flash side has a plain command strobe with a busy/fail status, plus two word streams. The write stream is driven by the scanner; `wr_valid` and `wr_data` stay stable until `wr_ready` is seen. The read stream is driven by the flash; a word moves on `rd_valid && rd_ready`, and `rd_ready` is high only during a read data phase. The report output is valid/ready; `rpt_blk`, `rpt_type` and `rpt_cause` stay stable while `rpt_valid` waits for `rpt_ready`, so a slow table writer stalls the scan.

Top module: `blkscan_top`

## Requirements
- R1: Commands are one-cycle `cmd_go` strobes with `cmd_op` 0 = erase, 1 = program, 2 = read. For blocks 0 to NBLK-1 in order, the scanner issues an erase and then, for pages 0 to NPG-1 in order, a program followed by a read of the same page.
- R2: Before each program command, NWD words are sent on the write stream in word order. Word w of page p carries `seed ^ i ^ (i << DATA_W/2)`, where i = {p, w} zero-extended to DATA_W. A word is held stable until `wr_ready`.
- R3: Each read word is compared with the pattern for its page and word. The whole page is always drained. Any mismatch reports the block with `rpt_cause` 1; a stuck bit that agrees with every pattern word causes no report.
- R4: The timeout counter restarts at each command. If `fl_busy` is still high after `tmo_limit` cycles, or a read data phase has not delivered all words within `tmo_limit` cycles of its read command, the block is reported with `rpt_cause` 2.
- R5: An erase that completes (`fl_busy` low) with `fl_fail` high reports the block with `rpt_cause` 3, and that block receives no program command.
- R6: A report carries `rpt_blk` and `rpt_type` = 2'b01 (factory bad). There is exactly one report per failing block, issued in block order. The fields are held stable while `rpt_valid` is high and `rpt_ready` is low.
- R7: After a report is accepted, no further command is issued for that block. The next command is the erase of the next block, or none if the reported block was the last.
- R8: After the last block, `done` pulses for one cycle and `scan_busy` falls in the same cycle. `bad_count` then equals the number of accepted reports; it is cleared when a scan starts.
- R9: After reset the scanner is idle: `scan_busy`, `cmd_go`, `wr_valid`, `rd_ready`, `rpt_valid` and `done` are low and `bad_count` is 0.
- R10: A `start` pulse during a running scan is ignored; the scan continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a scan when idle |
| seed | input | DATA_W | Pattern seed, held stable during a scan |
| tmo_limit | input | TMO_W | Timeout in cycles, held stable during a scan |
| cmd_go | output | 1 | One-cycle flash command strobe |
| cmd_op | output | 2 | Command code: 0 erase, 1 program, 2 read |
| cmd_blk | output | BLK_W | Block address of the command |
| cmd_page | output | PG_W | Page address of the command |
| fl_busy | input | 1 | Flash operation in progress |
| fl_fail | input | 1 | Erase failure status, valid while not busy |
| wr_valid | output | 1 | Write word valid |
| wr_ready | input | 1 | Flash accepts write word |
| wr_data | output | DATA_W | Write word |
| rd_valid | input | 1 | Read word valid |
| rd_ready | output | 1 | Scanner accepts read word |
| rd_data | input | DATA_W | Read word |
| rpt_valid | output | 1 | Bad-block report valid |
| rpt_ready | input | 1 | Table writer accepts report |
| rpt_blk | output | BLK_W | Reported block address |
| rpt_type | output | 2 | Bad-block type, 2'b01 = factory bad |
| rpt_cause | output | 2 | 1 mismatch, 2 timeout, 3 erase failure |
| scan_busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle pulse at end of scan |
| bad_count | output | CNT_W | Number of blocks reported in the last scan |

## Verification
The assertions assume the following about the environment:
- the flash accepts a command in any cycle, and a new command abandons the operation in progress;
- `fl_fail` is only looked at once `fl_busy` is low after an erase;
- `seed` and `tmo_limit` do not change during a scan.

The bench model follows these rules. It resets its operation on every `cmd_go` and sets its status only on erase completion. The bench changes seed and timeout only between scans. It randomizes write-ready, read-valid gaps, report back-pressure and operation latency, with the worst legal latency and gaps kept well inside the chosen timeout. As a result, timeouts arise only from injected hangs.

// File: rtl/blkscan_pkg.sv
package blkscan_pkg;
  localparam logic [1:0] OP_ERASE = 2'd0;
  localparam logic [1:0] OP_PROG  = 2'd1;
  localparam logic [1:0] OP_READ  = 2'd2;

  localparam logic [1:0] CAUSE_MISMATCH = 2'd1;
  localparam logic [1:0] CAUSE_TIMEOUT  = 2'd2;
  localparam logic [1:0] CAUSE_ERASE    = 2'd3;

  localparam logic [1:0] TYPE_FACTORY = 2'b01;

  typedef enum logic [3:0] {
    S_IDLE, S_ECMD, S_EWAIT, S_LOAD, S_PCMD, S_PWAIT,
    S_RCMD, S_RWAIT, S_RDATA, S_RPT, S_NEXT
  } scan_state_e;
endpackage

// File: rtl/blkscan_patgen.sv
module blkscan_patgen #(
  parameter int DATA_W = 16,
  parameter int PG_W   = 2,
  parameter int WD_W   = 3
) (
  input  logic [DATA_W-1:0] seed,
  input  logic [PG_W-1:0]   page,
  input  logic [WD_W-1:0]   word,
  output logic [DATA_W-1:0] pat
);
  localparam int HALF = DATA_W / 2;
  logic [DATA_W-1:0] idx;

  always_comb begin
    idx = DATA_W'({page, word});
    pat = seed ^ idx ^ (idx << HALF);
  end
endmodule

// File: rtl/blkscan_timer.sv
module blkscan_timer #(
  parameter int TMO_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic [TMO_W-1:0] limit,
  output logic             expired
);
  localparam logic [TMO_W-1:0] CNT_MAX = '1;
  logic [TMO_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt <= '0;
    else if (clr)                   cnt <= '0;
    else if (run && cnt != CNT_MAX) cnt <= cnt + 1'b1;
  end

  assign expired = run && (cnt >= limit);

  AST_TMO_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0)) else $error("timer not restarted"); // R4
endmodule

// File: rtl/blkscan_cmp.sv
module blkscan_cmp #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              en,
  input  logic [DATA_W-1:0] got,
  input  logic [DATA_W-1:0] want,
  output logic              miss_now,
  output logic              miss_seen
);
  assign miss_now = en && (got != want);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        miss_seen <= 1'b0;
    else if (clr)      miss_seen <= 1'b0;
    else if (miss_now) miss_seen <= 1'b1;
  end

  AST_MISS_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_now && !clr) |=> miss_seen) else $error("mismatch lost"); // R3
endmodule

// File: rtl/blkscan_top.sv
module blkscan_top
  import blkscan_pkg::*;
#(
  parameter int NBLK   = 8,
  parameter int NPG    = 4,
  parameter int NWD    = 8,
  parameter int DATA_W = 16,
  parameter int TMO_W  = 8,
  localparam int BLK_W = $clog2(NBLK),
  localparam int PG_W  = $clog2(NPG),
  localparam int WD_W  = $clog2(NWD),
  localparam int CNT_W = $clog2(NBLK + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] seed,
  input  logic [TMO_W-1:0]  tmo_limit,
  output logic              cmd_go,
  output logic [1:0]        cmd_op,
  output logic [BLK_W-1:0]  cmd_blk,
  output logic [PG_W-1:0]   cmd_page,
  input  logic              fl_busy,
  input  logic              fl_fail,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [DATA_W-1:0] wr_data,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [DATA_W-1:0] rd_data,
  output logic              rpt_valid,
  input  logic              rpt_ready,
  output logic [BLK_W-1:0]  rpt_blk,
  output logic [1:0]        rpt_type,
  output logic [1:0]        rpt_cause,
  output logic              scan_busy,
  output logic              done,
  output logic [CNT_W-1:0]  bad_count
);
  localparam logic [BLK_W-1:0] BLK_LAST = BLK_W'(NBLK - 1);
  localparam logic [PG_W-1:0]  PG_LAST  = PG_W'(NPG - 1);
  localparam logic [WD_W-1:0]  WD_LAST  = WD_W'(NWD - 1);

  scan_state_e       state;
  logic [BLK_W-1:0]  blk;
  logic [PG_W-1:0]   pg;
  logic [WD_W-1:0]   wd;
  logic              fresh;
  logic [1:0]        cause;
  logic [DATA_W-1:0] pat;
  logic              tmo_run, tmo_exp;
  logic              miss_now, miss_seen;

  blkscan_patgen #(.DATA_W(DATA_W), .PG_W(PG_W), .WD_W(WD_W)) u_pat (
    .seed(seed), .page(pg), .word(wd), .pat(pat));

  assign tmo_run = (state == S_EWAIT) || (state == S_PWAIT) ||
                   (state == S_RWAIT) || (state == S_RDATA);

  blkscan_timer #(.TMO_W(TMO_W)) u_tmo (
    .clk(clk), .rst_n(rst_n), .clr(cmd_go), .run(tmo_run),
    .limit(tmo_limit), .expired(tmo_exp));

  blkscan_cmp #(.DATA_W(DATA_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .clr(state == S_RCMD),
    .en(state == S_RDATA && rd_valid), .got(rd_data), .want(pat),
    .miss_now(miss_now), .miss_seen(miss_seen));

  always_comb begin
    cmd_go = (state == S_ECMD) || (state == S_PCMD) || (state == S_RCMD);
    unique case (state)
      S_PCMD:  cmd_op = OP_PROG;
      S_RCMD:  cmd_op = OP_READ;
      default: cmd_op = OP_ERASE;
    endcase
  end

  assign cmd_blk   = blk;
  assign cmd_page  = pg;
  assign wr_valid  = (state == S_LOAD);
  assign wr_data   = pat;
  assign rd_ready  = (state == S_RDATA);
  assign rpt_valid = (state == S_RPT);
  assign rpt_blk   = blk;
  assign rpt_type  = TYPE_FACTORY;
  assign rpt_cause = cause;
  assign scan_busy = (state != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      blk       <= '0;
      pg        <= '0;
      wd        <= '0;
      fresh     <= 1'b0;
      cause     <= '0;
      bad_count <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        S_IDLE: if (start) begin
          blk       <= '0;
          bad_count <= '0;
          state     <= S_ECMD;
        end
        S_ECMD: begin fresh <= 1'b1; state <= S_EWAIT; end
        S_EWAIT:
          if (fresh) fresh <= 1'b0;
          else if (!fl_busy) begin
            if (fl_fail) begin cause <= CAUSE_ERASE; state <= S_RPT; end
            else begin pg <= '0; wd <= '0; state <= S_LOAD; end
          end else if (tmo_exp) begin cause <= CAUSE_TIMEOUT; state <= S_RPT; end
        S_LOAD: if (wr_ready) begin
          if (wd == WD_LAST) begin wd <= '0; state <= S_PCMD; end
          else wd <= wd + 1'b1;
        end
        S_PCMD: begin fresh <= 1'b1; state <= S_PWAIT; end
        S_PWAIT:
          if (fresh) fresh <= 1'b0;
          else if (!fl_busy) state <= S_RCMD;
          else if (tmo_exp) begin cause <= CAUSE_TIMEOUT; state <= S_RPT; end
        S_RCMD: begin fresh <= 1'b1; wd <= '0; state <= S_RWAIT; end
        S_RWAIT:
          if (fresh) fresh <= 1'b0;
          else if (!fl_busy) state <= S_RDATA;
          else if (tmo_exp) begin cause <= CAUSE_TIMEOUT; state <= S_RPT; end
        S_RDATA:
          if (rd_valid) begin
            if (wd == WD_LAST) begin
              wd <= '0;
              if (miss_seen || miss_now) begin
                cause <= CAUSE_MISMATCH; state <= S_RPT;
              end else if (pg == PG_LAST) state <= S_NEXT;
              else begin pg <= pg + 1'b1; state <= S_LOAD; end
            end else wd <= wd + 1'b1;
          end else if (tmo_exp) begin cause <= CAUSE_TIMEOUT; state <= S_RPT; end
        S_RPT: if (rpt_ready) begin
          bad_count <= bad_count + 1'b1;
          state     <= S_NEXT;
        end
        S_NEXT:
          if (blk == BLK_LAST) begin done <= 1'b1; state <= S_IDLE; end
          else begin blk <= blk + 1'b1; state <= S_ECMD; end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_CMD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_go |=> !cmd_go) else $error("command strobe too long"); // R1
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data))) else $error("write word dropped"); // R2
  AST_NO_PROG_AFTER_EFAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_EWAIT && !fresh && !fl_busy && fl_fail) |=> rpt_valid) else $error("erase fail not reported"); // R5
  AST_RPT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt_valid && !rpt_ready) |=> (rpt_valid && $stable(rpt_blk) && $stable(rpt_cause))) else $error("report unstable"); // R6
  AST_SKIP_AFTER_RPT: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt_valid && rpt_ready) |=> ##1 ((cmd_go && cmd_op == OP_ERASE) || !scan_busy)) else $error("pages not skipped"); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!scan_busy && !$past(done))) else $error("done malformed"); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_busy |-> (!cmd_go && !wr_valid && !rd_ready && !rpt_valid)) else $error("idle not quiet"); // R9
endmodule

// File: tb/sim_blkscan_top.sv
module sim_blkscan_top;
  localparam int NBLK = 8, NPG = 4, NWD = 8, DW = 16, TW = 8;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [DW-1:0] seed = '0;
  logic [TW-1:0] tmo_limit = 8'd60;
  logic cmd_go; logic [1:0] cmd_op; logic [2:0] cmd_blk; logic [1:0] cmd_page;
  logic fl_busy = 1'b0, fl_fail = 1'b0;
  logic wr_valid, wr_ready = 1'b0; logic [DW-1:0] wr_data;
  logic rd_valid = 1'b0, rd_ready; logic [DW-1:0] rd_data = '0;
  logic rpt_valid, rpt_ready = 1'b0; logic [2:0] rpt_blk; logic [1:0] rpt_type, rpt_cause;
  logic scan_busy, done; logic [3:0] bad_count;

  always #5 clk = ~clk;

  blkscan_top #(.NBLK(NBLK), .NPG(NPG), .NWD(NWD), .DATA_W(DW), .TMO_W(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .seed(seed), .tmo_limit(tmo_limit),
    .cmd_go(cmd_go), .cmd_op(cmd_op), .cmd_blk(cmd_blk), .cmd_page(cmd_page),
    .fl_busy(fl_busy), .fl_fail(fl_fail), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .rpt_valid(rpt_valid), .rpt_ready(rpt_ready), .rpt_blk(rpt_blk), .rpt_type(rpt_type),
    .rpt_cause(rpt_cause), .scan_busy(scan_busy), .done(done), .bad_count(bad_count));

  int n_chk = 0, n_err = 0, cyc = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // fault configuration per block
  logic efail[NBLK], hang_en[NBLK], stk_en[NBLK], stk_val[NBLK];
  int hang_op[NBLK], hang_pg[NBLK], stk_pg[NBLK], stk_bit[NBLK];

  function automatic logic [DW-1:0] pat_of(input logic [DW-1:0] s, input int p, input int w);
    logic [DW-1:0] i;
    i = DW'(p * NWD + w);
    return s ^ i ^ (i << (DW / 2));
  endfunction

  function automatic int exp_cause(input int b);
    if (hang_en[b] && hang_op[b] == 0) return 2;
    if (efail[b]) return 3;
    for (int p = 0; p < NPG; p++) begin
      if (hang_en[b] && hang_op[b] == 1 && hang_pg[b] == p) return 2;
      if (hang_en[b] && hang_op[b] == 2 && hang_pg[b] == p) return 2;
      if (stk_en[b] && stk_pg[b] == p)
        for (int w = 0; w < NWD; w++)
          if (pat_of(seed, p, w)[stk_bit[b]] != stk_val[b]) return 1;
    end
    return 0;
  endfunction

  // flash model
  logic [DW-1:0] mem[NBLK*NPG*NWD];
  logic [DW-1:0] wbuf[NWD];
  int wcnt = 0, lat = 0, m_op = 0, m_blk = 0, m_pg = 0, rd_idx = 0, wr_err = 0;
  logic rd_active = 1'b0;

  function automatic logic [DW-1:0] rdword(input int b, input int p, input int w);
    logic [DW-1:0] v;
    v = mem[(b * NPG + p) * NWD + w];
    if (stk_en[b] && stk_pg[b] == p) v[stk_bit[b]] = stk_val[b];
    return v;
  endfunction

  always @(posedge clk) begin
    wr_ready  <= ($urandom % 3) != 0;
    rpt_ready <= ($urandom % 3) != 0;
    if (wr_valid && wr_ready && wcnt < NWD) begin wbuf[wcnt] <= wr_data; wcnt <= wcnt + 1; end
    if (cmd_go) begin
      fl_busy <= 1'b1; fl_fail <= 1'b0; lat <= 1 + $urandom % 5;
      m_op <= cmd_op; m_blk <= cmd_blk; m_pg <= cmd_page;
      rd_active <= 1'b0; rd_valid <= 1'b0;
      if (cmd_op == 2'd1) begin
        for (int w = 0; w < NWD; w++) begin
          mem[(cmd_blk * NPG + cmd_page) * NWD + w] <= wbuf[w];
          if (wbuf[w] != pat_of(seed, cmd_page, w) || wcnt != NWD) wr_err <= wr_err + 1;
        end
        wcnt <= 0;
      end
    end else if (fl_busy) begin
      if (!(hang_en[m_blk] && hang_op[m_blk] == m_op && (m_op == 0 || hang_pg[m_blk] == m_pg))) begin
        if (lat > 1) lat <= lat - 1;
        else begin
          fl_busy <= 1'b0;
          if (m_op == 0) begin
            fl_fail <= efail[m_blk];
            for (int i = 0; i < NPG * NWD; i++) mem[m_blk * NPG * NWD + i] <= '1;
          end
          if (m_op == 2) begin rd_active <= 1'b1; rd_idx <= 0; end
        end
      end
    end else if (rd_active) begin
      int nx;
      nx = (rd_valid && rd_ready) ? rd_idx + 1 : rd_idx;
      rd_idx <= nx;
      if (nx >= NWD) begin rd_active <= 1'b0; rd_valid <= 1'b0; end
      else if (!(rd_valid && !rd_ready)) begin
        rd_valid <= ($urandom % 4) != 0;
        rd_data  <= rdword(m_blk, m_pg, nx);
      end
    end
  end

  // monitors
  int rep_blk[NBLK], rep_cause[NBLK], rep_type[NBLK], nrep = 0, ndone = 0, done_bc = 0;
  int seq_err = 0, skip_err = 0, r5_err = 0, hold_err = 0, dwide = 0;
  int cur_blk = -1, exp_pg = 0, last_prog = -1, after_rpt = -1;
  logic p_rv = 1'b0, p_rr = 1'b0, p_done = 1'b0; logic [2:0] p_rb = '0; logic [1:0] p_rc = '0;

  always @(negedge clk) begin
    cyc++;
    if (p_rv && !p_rr && (!rpt_valid || rpt_blk != p_rb || rpt_cause != p_rc)) hold_err++;
    p_rv = rpt_valid; p_rr = rpt_ready; p_rb = rpt_blk; p_rc = rpt_cause;
    if (rpt_valid && rpt_ready && nrep < NBLK) begin
      rep_blk[nrep] = rpt_blk; rep_cause[nrep] = rpt_cause; rep_type[nrep] = rpt_type;
      nrep++; after_rpt = rpt_blk;
    end
    if (done) begin ndone++; done_bc = bad_count; if (p_done) dwide++; end
    p_done = done;
    if (cmd_go) begin
      if (after_rpt >= 0 && !(cmd_op == 0 && cmd_blk == after_rpt + 1)) skip_err++;
      after_rpt = -1;
      case (cmd_op)
        2'd0: begin
          if (cmd_blk != cur_blk + 1) seq_err++;
          cur_blk = cmd_blk; exp_pg = 0; last_prog = -1;
        end
        2'd1: begin
          if (cmd_blk != cur_blk || cmd_page != exp_pg) seq_err++;
          if (efail[cmd_blk]) r5_err++;
          last_prog = cmd_page;
        end
        2'd2: begin
          if (cmd_blk != cur_blk || cmd_page != last_prog) seq_err++;
          exp_pg = last_prog + 1;
        end
        default: seq_err++;
      endcase
    end
  end

  task automatic clear_faults();
    for (int b = 0; b < NBLK; b++) begin
      efail[b] = 0; hang_en[b] = 0; stk_en[b] = 0; stk_val[b] = 0;
      hang_op[b] = 0; hang_pg[b] = 0; stk_pg[b] = 0; stk_bit[b] = 0;
    end
  endtask

  task automatic run_scan(input string tag);
    int eb[NBLK]; int ec[NBLK]; int ne;
    ne = 0;
    for (int b = 0; b < NBLK; b++) begin
      int c; c = exp_cause(b);
      if (c != 0) begin eb[ne] = b; ec[ne] = c; ne++; end
    end
    nrep = 0; ndone = 0; dwide = 0; seq_err = 0; skip_err = 0; r5_err = 0;
    hold_err = 0; wr_err = 0; cur_blk = -1; after_rpt = -1;
    @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (40) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;   // R10: ignored mid-scan
    chk(scan_busy == 1'b1, "R10 busy after mid-scan start", scan_busy, 1);
    for (int t = 0; t < 20000 && ndone == 0; t++) @(negedge clk);
    repeat (3) @(negedge clk);
    $display("scan %s: %0d bad", tag, ne);
    chk(ndone == 1, "R8 done pulses (R10 no restart)", ndone, 1);
    chk(dwide == 0, "R8 done one cycle", dwide, 0);
    chk(done_bc == ne, "R8 bad_count", done_bc, ne);
    chk(!scan_busy, "R8 idle after done", scan_busy, 0);
    chk(nrep == ne, "R6 report count", nrep, ne);
    for (int i = 0; i < ne && i < nrep; i++) begin
      chk(rep_blk[i] == eb[i], "R6 report block", rep_blk[i], eb[i]);
      chk(rep_type[i] == 1, "R6 report type", rep_type[i], 1);
      chk(rep_cause[i] == ec[i], "R3/R4/R5 report cause", rep_cause[i], ec[i]);
    end
    chk(seq_err == 0, "R1 command order", seq_err, 0);
    chk(wr_err == 0, "R2 written pattern", wr_err, 0);
    chk(r5_err == 0, "R5 no program after erase fail", r5_err, 0);
    chk(hold_err == 0, "R6 report held under back-pressure", hold_err, 0);
    chk(skip_err == 0, "R7 next command after report", skip_err, 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    clear_faults();
    repeat (4) @(negedge clk);
    chk(!scan_busy && !cmd_go && !rpt_valid, "R9 reset quiet", scan_busy, 0);
    chk(!wr_valid && !rd_ready && !done, "R9 reset streams idle", wr_valid, 0);
    chk(bad_count == 0, "R9 reset bad_count", bad_count, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!scan_busy, "R9 idle after reset release", scan_busy, 0);

    seed = 16'hA5C3;
    run_scan("clean");

    // directed corners
    seed = 16'h3C5A;
    efail[0] = 1;                                         // R5
    stk_en[2] = 1; stk_pg[2] = 0; stk_bit[2] = 0; stk_val[2] = 0;  // R3 mismatch
    hang_en[3] = 1; hang_op[3] = 1; hang_pg[3] = 1;       // R4 program hang
    hang_en[5] = 1; hang_op[5] = 0;                       // R4 erase hang
    stk_en[6] = 1; stk_pg[6] = 0; stk_bit[6] = 15; stk_val[6] = seed[15]; // R3 agreeing stuck bit
    hang_en[7] = 1; hang_op[7] = 2; hang_pg[7] = 3;       // R4 read hang, last block
    run_scan("directed");
    chk(exp_cause(6) == 0, "R3 agreeing stuck bit not bad", exp_cause(6), 0);

    for (int r = 0; r < 4; r++) begin
      clear_faults();
      seed = DW'($urandom);
      for (int b = 0; b < NBLK; b++) begin
        efail[b] = ($urandom % 8) == 0;
        hang_en[b] = ($urandom % 6) == 0; hang_op[b] = $urandom % 3; hang_pg[b] = $urandom % NPG;
        stk_en[b] = ($urandom % 4) == 0; stk_pg[b] = $urandom % NPG;
        stk_bit[b] = $urandom % DW; stk_val[b] = $urandom % 2;
      end
      run_scan("random");
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule